// File: doc/BRIEF.md
# Bus-Idle-Gated Message Transmit Sequencer

This block runs the transmit side of a single-wire consumer-electronics control bus. It works at the level of messages and bytes. Software asks for a message to start. The block then waits until the bus has been quiet for a configurable time. After that it hands the header byte to a bit serializer. The header byte carries the initiator and destination logical addresses. Up to fifteen payload bytes follow, and the block fetches each one through a byte-request handshake.

The idle wait is counted in half-bit-period steps, and its length depends on a 3-bit setting. When the setting is zero, the wait also depends on what happened last on the bus: a message by another device, a failed attempt by this device, or a successful message by this device. The idle timer can start at the start command or when the previous message ends.

Each serialized byte returns an acknowledge, arbitration-lost and error indication. The block turns these into sticky status flags and a maskable interrupt. The bit-level waveform and the line driver belong to the serializer and are not part of this block.

Top module: `cec_tx_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `byte_req`, `ser_start`, `flags` and `irq` are all 0.
- R2: With `cfg_auto_sft`=0 and `cfg_sft`=n (n from 1 to 7), `ser_start` rises (2n-1)·HALF_CYC clock cycles after the clock edge that accepts `som_set`. One half-bit period is HALF_CYC cycles.
- R3: With `cfg_sft`=0, the wait depends on the last bus event:
  - 10 half-bits after reset, after a received message, or after an arbitration loss.
  - 6 half-bits after this block's own message failed by missing acknowledge, error or underrun.
  - 14 half-bits after this block's own message succeeded.
- R4: With `cfg_auto_sft`=1, the idle timer restarts at the end of every transmitted message and at every `rx_msg_end` pulse. A `som_set` arriving after the wait has elapsed starts the header one cycle later.
- R5: The header byte on `ser_byte` is `{cfg_init_addr, cfg_dest_addr}`, with the initiator in bits 7:4 and the destination in bits 3:0.
- R6: If `eom_set` is pulsed before or together with `som_set`, the message is header only: the header carries `ser_last`=1 and `byte_req` stays 0.
- R7: While a non-last byte is being serialized, `byte_req` is 1. A `tx_wr` clears it and queues `tx_wdata`. A write made together with `eom_set` marks that byte as last. Queued bytes are sent in write order as soon as the previous byte is acknowledged.
- R8: The 15th payload byte is always marked last, even without `eom_set`.
- R9: If a non-last byte is acknowledged while no next byte is queued, the block sets the underrun flag (bit 1) and returns to idle.
- R10: On arbitration loss the block sets flag bit 2 and returns to idle at once. It does not start again until a new `som_set` arrives.
- R11: A byte's outcome is judged with arbitration loss first, then error (bit 4), then missing acknowledge (bit 3). Only the highest-ranked cause sets its flag.
- R12: When the last byte is acknowledged, flag bit 0 (end of transmission) is set and `busy` returns to 0.
- R13: Flags stay set until a 1 is written to the matching bit of `flag_clr`. Clearing one bit leaves the others unchanged.
- R14: `irq` is 1 exactly when some flag is set and its bit in `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sft | input | 3 | Idle-wait setting |
| cfg_auto_sft | input | 1 | 1: idle timer starts at end of message; 0: at start command |
| cfg_init_addr | input | 4 | Own (initiator) logical address |
| cfg_dest_addr | input | 4 | Destination logical address |
| som_set | input | 1 | Start-of-message command pulse |
| eom_set | input | 1 | End-of-message mark pulse |
| tx_wr | input | 1 | Payload byte write strobe |
| tx_wdata | input | 8 | Payload byte |
| rx_msg_end | input | 1 | Pulse: a received message has ended |
| flag_clr | input | 5 | Write-1-to-clear for flags |
| irq_en | input | 5 | Interrupt enable per flag |
| ser_done | input | 1 | Serializer finished current byte |
| ser_ack | input | 1 | Byte was acknowledged |
| ser_arb_lost | input | 1 | Arbitration lost on this byte |
| ser_err | input | 1 | Line error on this byte |
| busy | output | 1 | A message is waiting or in progress |
| byte_req | output | 1 | Next payload byte is wanted |
| ser_start | output | 1 | One-cycle pulse: serialize `ser_byte` |
| ser_byte | output | 8 | Byte for the serializer |
| ser_last | output | 1 | `ser_byte` is the last byte of the message |
| flags | output | 5 | Sticky flags: 0 end, 1 underrun, 2 arbitration lost, 3 missing ack, 4 error |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is the history-dependent default wait. Each of the three cases needs a particular earlier outcome: a received message, an arbitration loss, a failed attempt, or a successful message by this device. The stimulus table therefore chains several messages in a row. Each row's acknowledge response sets up the history that the next row's expected delay depends on. The automatic-timer mode is reached the same way: an `rx_msg_end` pulse is issued one cycle before the start command, so the count that began at that pulse is measured exactly.

// File: rtl/cec_tx_pkg.sv
// Shared types and the idle-wait length function for the transmit sequencer.
package cec_tx_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND} tx_state_e;

    typedef enum logic [1:0] {PK_NEW, PK_RETRY, PK_SAME} prev_kind_e;

    localparam int FLAG_W  = 5;
    localparam int FL_END  = 0;
    localparam int FL_UDR  = 1;
    localparam int FL_ARB  = 2;
    localparam int FL_NACK = 3;
    localparam int FL_ERR  = 4;
    localparam int ADDR_W  = 4;
    localparam int MAX_HALVES = 14;

    // Idle wait in half-bit periods for a setting and the previous bus event.
    function automatic int unsigned wait_halves(input logic [2:0] sft, input prev_kind_e kind);
        if (sft != 3'd0)
            return 2 * int'(sft) - 1;
        case (kind)
            PK_RETRY: return 6;
            PK_SAME:  return 14;
            default:  return 10;
        endcase
    endfunction

endpackage

// File: rtl/cec_sft_timer.sv
// Idle-wait timer. It counts clock cycles since the last restart and reports
// when the required number of half-bit periods has elapsed. It also remembers
// the kind of the last bus event, because the default wait depends on it.
// Assumes the end-of-message strobes are single-cycle pulses.
module cec_sft_timer
    import cec_tx_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cfg_sft,
    input  logic       cfg_auto_sft,
    input  logic       som_accept,
    input  logic       tx_ok,
    input  logic       tx_fail,
    input  logic       tx_lost,
    input  logic       rx_end,
    output logic       timer_done
);
    localparam int CNT_MAX = MAX_HALVES * HALF_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);

    logic [CW-1:0] fcnt;
    prev_kind_e    kind;
    logic          restart;
    int            need;

    assign restart = cfg_auto_sft ? (tx_ok | tx_fail | tx_lost | rx_end) : som_accept;
    assign need    = int'(wait_halves(cfg_sft, kind)) * HALF_CYC;
    assign timer_done = (int'(fcnt) + 1) >= need;

    // Saturating count of cycles since the last restart.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fcnt <= '0;
        else if (restart)
            fcnt <= '0;
        else if (int'(fcnt) != CNT_MAX)
            fcnt <= fcnt + 1'b1;
    end

    // Record the kind of the most recent bus event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            kind <= PK_NEW;
        else if (rx_end || tx_lost)
            kind <= PK_NEW;
        else if (tx_fail)
            kind <= PK_RETRY;
        else if (tx_ok)
            kind <= PK_SAME;
    end

    // R2
    fcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fcnt) <= CNT_MAX);

endmodule

// File: rtl/cec_tx_flags.sv
// Sticky status flags with write-1-to-clear and a masked interrupt.
// In the same cycle, setting a flag wins over clearing it.
module cec_tx_flags #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] flags,
    output logic         irq
);
    for (genvar i = 0; i < W; i++) begin : g_flag
        // Hold one flag until it is cleared by software.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else
                flags[i] <= set_i[i] | (flags[i] & ~clr_i[i]);
        end

        // R13
        sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            flags[i] && !clr_i[i] |=> flags[i]);
    end

    assign irq = |(flags & en_i);

endmodule

// File: rtl/cec_tx_fsm.sv
// Message/byte sequencer. It accepts the start command, waits for the idle
// timer, then feeds the header and the queued payload bytes to the
// serializer one at a time and judges each byte's outcome.
// Assumes the serializer raises ser_done at the earliest one cycle after ser_start.
module cec_tx_fsm
    import cec_tx_pkg::*;
#(
    parameter int MAX_PAY = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              som_set,
    input  logic              eom_set,
    input  logic              tx_wr,
    input  logic [7:0]        tx_wdata,
    input  logic [ADDR_W-1:0] init_addr,
    input  logic [ADDR_W-1:0] dest_addr,
    input  logic              timer_done,
    input  logic              ser_done,
    input  logic              ser_ack,
    input  logic              ser_arb_lost,
    input  logic              ser_err,
    output logic              busy,
    output logic              byte_req,
    output logic              ser_start,
    output logic [7:0]        ser_byte,
    output logic              ser_last,
    output logic              som_accept,
    output logic [FLAG_W-1:0] flag_set,
    output logic              tx_ok,
    output logic              tx_fail,
    output logic              tx_lost
);
    localparam int PW = $clog2(MAX_PAY + 1);

    tx_state_e     state;
    logic          eom_pend, hdr_last;
    logic [7:0]    nbuf;
    logic          nbuf_valid, nbuf_last;
    logic [PW-1:0] pay_cnt;
    logic          done_here, good, err_c, nack_c, udr_c, wr_ok, wr_last;

    assign done_here  = (state == ST_SEND) && ser_done;
    assign tx_lost    = done_here && ser_arb_lost;
    assign err_c      = done_here && !ser_arb_lost && ser_err;
    assign nack_c     = done_here && !ser_arb_lost && !ser_err && !ser_ack;
    assign good       = done_here && !ser_arb_lost && !ser_err && ser_ack;
    assign udr_c      = good && !ser_last && !nbuf_valid;
    assign tx_ok      = good && ser_last;
    assign tx_fail    = err_c | nack_c | udr_c;
    assign som_accept = (state == ST_IDLE) && som_set;
    assign wr_ok      = tx_wr && byte_req;
    assign wr_last    = eom_pend || eom_set || (pay_cnt == PW'(MAX_PAY - 1));
    assign busy       = (state != ST_IDLE);

    always_comb begin
        flag_set          = '0;
        flag_set[FL_END]  = tx_ok;
        flag_set[FL_UDR]  = udr_c;
        flag_set[FL_ARB]  = tx_lost;
        flag_set[FL_NACK] = nack_c;
        flag_set[FL_ERR]  = err_c;
    end

    // End-of-message mark: held until a header or payload byte uses it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            eom_pend <= 1'b0;
        else if (som_accept || wr_ok)
            eom_pend <= 1'b0;
        else if (eom_set)
            eom_pend <= 1'b1;
        else if (tx_ok || tx_fail || tx_lost)
            eom_pend <= 1'b0;
    end

    // Main sequencing: idle, free-time wait, byte in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            hdr_last   <= 1'b0;
            nbuf       <= '0;
            nbuf_valid <= 1'b0;
            nbuf_last  <= 1'b0;
            pay_cnt    <= '0;
            byte_req   <= 1'b0;
            ser_start  <= 1'b0;
            ser_byte   <= '0;
            ser_last   <= 1'b0;
        end else begin
            ser_start <= 1'b0;
            if (wr_ok) begin
                nbuf       <= tx_wdata;
                nbuf_last  <= wr_last;
                nbuf_valid <= 1'b1;
                byte_req   <= 1'b0;
                pay_cnt    <= pay_cnt + 1'b1;
            end
            case (state)
                ST_IDLE: begin
                    if (som_set) begin
                        state      <= ST_WAIT;
                        hdr_last   <= eom_pend | eom_set;
                        pay_cnt    <= '0;
                        nbuf_valid <= 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (timer_done) begin
                        state     <= ST_SEND;
                        ser_start <= 1'b1;
                        ser_byte  <= {init_addr, dest_addr};
                        ser_last  <= hdr_last;
                        byte_req  <= !hdr_last;
                    end
                end
                default: begin
                    if (good && !ser_last && nbuf_valid) begin
                        ser_start  <= 1'b1;
                        ser_byte   <= nbuf;
                        ser_last   <= nbuf_last;
                        byte_req   <= !nbuf_last;
                        nbuf_valid <= 1'b0;
                    end else if (done_here) begin
                        state      <= ST_IDLE;
                        byte_req   <= 1'b0;
                        nbuf_valid <= 1'b0;
                    end
                end
            endcase
        end
    end

    // R7
    byte_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !byte_req);

    // R7
    ser_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_start |=> !ser_start);

    // R10
    arb_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_lost |=> (state == ST_IDLE) && !ser_start && !byte_req);

    // R8
    pay_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pay_cnt) <= MAX_PAY);

endmodule

// File: rtl/cec_tx_seq.sv
// Top of the transmit sequencer: connects the message FSM, the idle-wait
// timer and the sticky flag bank. The bit serializer sits outside.
module cec_tx_seq
    import cec_tx_pkg::*;
#(
    parameter int HALF_CYC = 4,
    parameter int MAX_PAY  = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  cfg_sft,
    input  logic        cfg_auto_sft,
    input  logic [3:0]  cfg_init_addr,
    input  logic [3:0]  cfg_dest_addr,
    input  logic        som_set,
    input  logic        eom_set,
    input  logic        tx_wr,
    input  logic [7:0]  tx_wdata,
    input  logic        rx_msg_end,
    input  logic [4:0]  flag_clr,
    input  logic [4:0]  irq_en,
    input  logic        ser_done,
    input  logic        ser_ack,
    input  logic        ser_arb_lost,
    input  logic        ser_err,
    output logic        busy,
    output logic        byte_req,
    output logic        ser_start,
    output logic [7:0]  ser_byte,
    output logic        ser_last,
    output logic [4:0]  flags,
    output logic        irq
);
    logic              som_accept, timer_done, tx_ok, tx_fail, tx_lost;
    logic [FLAG_W-1:0] flag_set;

    cec_tx_fsm #(.MAX_PAY(MAX_PAY)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .som_set(som_set), .eom_set(eom_set),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .init_addr(cfg_init_addr), .dest_addr(cfg_dest_addr),
        .timer_done(timer_done),
        .ser_done(ser_done), .ser_ack(ser_ack),
        .ser_arb_lost(ser_arb_lost), .ser_err(ser_err),
        .busy(busy), .byte_req(byte_req),
        .ser_start(ser_start), .ser_byte(ser_byte), .ser_last(ser_last),
        .som_accept(som_accept), .flag_set(flag_set),
        .tx_ok(tx_ok), .tx_fail(tx_fail), .tx_lost(tx_lost)
    );

    cec_sft_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .cfg_sft(cfg_sft), .cfg_auto_sft(cfg_auto_sft),
        .som_accept(som_accept),
        .tx_ok(tx_ok), .tx_fail(tx_fail), .tx_lost(tx_lost),
        .rx_end(rx_msg_end),
        .timer_done(timer_done)
    );

    cec_tx_flags #(.W(FLAG_W)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_i(flag_set), .clr_i(flag_clr), .en_i(irq_en),
        .flags(flags), .irq(irq)
    );

    // R12
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ok |=> !busy);

endmodule

// File: tb/sim_cec_tx_seq.sv
module sim_cec_tx_seq;
    localparam int CLK_PERIOD = 10;
    localparam int H = 4;

    // Ping vectors: setting, acknowledge, expected delay, expected flags
    localparam int NV = 8;
    localparam int T_SFT [NV] = '{0, 0, 0, 0, 3, 1, 7, 2};
    localparam int T_ACK [NV] = '{1, 1, 0, 1, 1, 1, 0, 1};
    localparam int T_DLY [NV] = '{10*H, 14*H, 14*H, 6*H, 5*H, 1*H, 13*H, 3*H};
    localparam int T_FLG [NV] = '{1, 1, 8, 1, 1, 1, 8, 1};

    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] cfg_sft = '0;
    logic cfg_auto_sft = 1'b0;
    logic [3:0] cfg_init_addr = 4'h5, cfg_dest_addr = 4'h0;
    logic som_set = 0, eom_set = 0, tx_wr = 0, rx_msg_end = 0;
    logic [7:0] tx_wdata = '0;
    logic [4:0] flag_clr = '0, irq_en = '0;
    logic ser_done = 0, ser_ack = 0, ser_arb_lost = 0, ser_err = 0;
    logic busy, byte_req, ser_start, ser_last, irq;
    logic [7:0] ser_byte;
    logic [4:0] flags;
    int n_chk = 0, n_err = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cec_tx_seq #(.HALF_CYC(H), .MAX_PAY(15)) u0 (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse_eom();
        eom_set = 1; @(negedge clk); eom_set = 0;
    endtask

    task automatic start_msg(output int dly);
        som_set = 1; @(negedge clk); som_set = 0;
        dly = 0;
        while (!ser_start && dly < 3000) begin
            @(negedge clk); dly++;
        end
    endtask

    task automatic finish(input logic ack, input logic arb, input logic err);
        ser_done = 1; ser_ack = ack; ser_arb_lost = arb; ser_err = err;
        @(negedge clk);
        ser_done = 0; ser_ack = 0; ser_arb_lost = 0; ser_err = 0;
    endtask

    task automatic write_byte(input logic [7:0] d, input logic eom);
        tx_wr = 1; tx_wdata = d; eom_set = eom; @(negedge clk);
        tx_wr = 0; eom_set = 0;
    endtask

    task automatic clear_all();
        flag_clr = 5'h1f; @(negedge clk); flag_clr = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int d;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 byte_req", byte_req, 0);
        check("R1 ser_start", ser_start, 0);
        check("R1 flags", flags, 0);
        check("R1 irq", irq, 0);
        rst_n = 1; @(negedge clk);

        // Table of ping messages; history chains between rows (R2, R3, R5, R6, R11, R12)
        for (int i = 0; i < NV; i++) begin
            cfg_sft = 3'(T_SFT[i]);
            pulse_eom();
            start_msg(d);
            check(T_SFT[i] == 0 ? "R3 default wait" : "R2 wait", d, T_DLY[i]);
            check("R5 header", ser_byte, 8'h50);
            check("R6 ping last", ser_last, 1);
            check("R6 no byte_req", byte_req, 0);
            finish(T_ACK[i] != 0, 0, 0);
            check(T_ACK[i] != 0 ? "R12 end flag" : "R11 nack flag", flags, T_FLG[i]);
            check("R12 idle", busy, 0);
            clear_all();
        end

        // R7 multi-byte message with byte requests
        cfg_sft = 3'd1; cfg_init_addr = 4'h3; cfg_dest_addr = 4'hA;
        start_msg(d);
        check("R5 header 3A", ser_byte, 8'h3A);
        check("R7 header not last", ser_last, 0);
        check("R7 byte_req", byte_req, 1);
        write_byte(8'h55, 0);
        check("R7 req cleared", byte_req, 0);
        finish(1, 0, 0);
        check("R7 next start", ser_start, 1);
        check("R7 byte1", ser_byte, 8'h55);
        check("R7 byte1 last", ser_last, 0);
        check("R7 req again", byte_req, 1);
        write_byte(8'h66, 1);
        finish(1, 0, 0);
        check("R7 byte2", ser_byte, 8'h66);
        check("R7 byte2 last", ser_last, 1);
        check("R7 no req after last", byte_req, 0);
        finish(1, 0, 0);
        check("R12 end", flags, 5'h01);
        clear_all();

        // R9 underrun
        start_msg(d);
        finish(1, 0, 0);
        check("R9 underrun flag", flags, 5'h02);
        check("R9 idle", busy, 0);
        clear_all();

        // R10 arbitration lost, no restart
        start_msg(d);
        finish(0, 1, 1);
        check("R10 arb flag", flags, 5'h04);
        begin
            int seen = 0;
            for (int k = 0; k < 60; k++) begin
                if (ser_start || busy) seen++;
                @(negedge clk);
            end
            check("R10 stays idle", seen, 0);
        end

        // R11 error beats missing ack; R13 partial clear; R14 irq masking
        pulse_eom();
        start_msg(d);
        finish(0, 0, 1);
        check("R11 err flag", flags, 5'h14);
        irq_en = 5'h08; #1;
        check("R14 masked irq", irq, 0);
        irq_en = 5'h10; #1;
        check("R14 enabled irq", irq, 1);
        flag_clr = 5'h04; @(negedge clk); flag_clr = '0;
        check("R13 partial clear", flags, 5'h10);
        repeat (5) @(negedge clk);
        check("R13 sticky", flags, 5'h10);
        clear_all();
        check("R14 irq low", irq, 0);
        irq_en = '0;

        // R8 fifteen-byte limit
        start_msg(d);
        for (int k = 1; k <= 15; k++) begin
            write_byte(8'(k), 0);
            finish(1, 0, 0);
            check("R8 byte order", ser_byte, k);
            check("R8 last mark", ser_last, k == 15);
        end
        finish(1, 0, 0);
        check("R8 end", flags, 5'h01);
        clear_all();

        // R4 automatic timer start
        cfg_auto_sft = 1; cfg_sft = 3'd0;
        repeat (80) @(negedge clk);
        pulse_eom();
        start_msg(d);
        check("R4 expired wait", d, 1);
        finish(1, 0, 0);
        clear_all();
        pulse_eom();
        rx_msg_end = 1; @(negedge clk); rx_msg_end = 0;
        start_msg(d);
        check("R4 restart at rx end", d, 10*H - 1);
        finish(1, 0, 0);
        check("R4 end", flags, 5'h01);
        clear_all();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule